// File: doc/BRIEF.md
# IDE Bus-Master DMA Register Window

This block is the register file that a host uses to program a two-channel IDE bus-master DMA engine. The host reaches it through one 16-byte I/O window, and each channel gets an 8-byte slice. The low half of a slice holds a byte-wide control register and a byte-wide state register. The high half holds the 32-bit pointer to the transfer descriptor table. The block decodes the byte offset and the access size of every host access. It returns read data combinationally in the same cycle and commits writes on the next clock edge.

The DMA engine, which is outside this block, takes the run and direction bits and the table pointer from the output ports. It reports completion and faults through one-cycle event pulses, which set sticky bits in the state register. Software clears those bits by writing ones to them. Accesses the window does not support give a fixed all-ones read value and have no side effects, so a driver that probes the wrong width sees an obvious pattern.

Top module: `bmdma_regwin`

## Requirements
- R1: Channel i's control byte sits at window offset i*8 and its state byte at offset i*8+2. Its table pointer occupies offsets i*8+4 to i*8+7. Accesses to one channel never change the other channel.
- R2: A byte write to the control register keeps wdata bit 0 (run) and bit 3 (direction, 1 = toward memory) and drives them on `run_o` and `dir_o`. A read of the control register returns zero in every other bit.
- R3: State register bit 0 always reads the current run bit and ignores writes. Bits 5 and 6 are plain read/write capability flags. Bits 3, 4 and 7 read zero.
- R4: State bit 1 (fault) and bit 2 (done) are set by `evt_err` and `evt_done` pulses and cleared by writing 1 to them. An event in the same cycle as a clearing write leaves the bit set. `done_o` mirrors bit 2.
- R5: A byte read at offset 1 or 3 of a channel's control/state half returns 0xFF, and byte writes there change nothing.
- R6: Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = reserved (treated as 4 bytes wide). On the control/state half, any access other than 1 byte reads all ones of its width (0xFFFF or 0xFFFFFFFF, with zero above), and a write of that kind is dropped.
- R7: The table pointer is 32 bits, little-endian: the byte at offset +4+k is bits 8k+7..8k. It accepts byte accesses at any of its offsets, 2-byte accesses at +4 and +6, and 4-byte accesses at +4. Data is right-justified in `wdata` and `rdata`. Bits 1..0 always read 0.
- R8: A 2-byte or 4-byte access to the pointer half that is not naturally aligned, or that uses size code 3, reads all ones of its width and is dropped if it is a write.
- R9: A synchronous active-high reset clears run, direction, capability, fault, done and the pointer of every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Host access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 4 | Byte offset within the window |
| acc_size | input | 2 | Access size code |
| wdata | input | 32 | Right-justified write data |
| rdata | output | 32 | Right-justified read data, same cycle |
| evt_done | input | 2 | Per-channel completion event pulse |
| evt_err | input | 2 | Per-channel fault event pulse |
| run_o | output | 2 | Per-channel run bit |
| dir_o | output | 2 | Per-channel direction bit |
| done_o | output | 2 | Per-channel sticky done flag |
| ptr_o | output | 64 | Per-channel table pointers, channel 0 in bits 31..0 |

## Verification
The checker tests on every cycle these properties:
- the reserved control bits read zero;
- the active bit agrees with `run_o`;
- odd offsets read 0xFF;
- wide control reads return the all-ones pattern and wide control writes leave the run and direction outputs unchanged;
- events raise `done_o` on the next edge;
- pointer bits 1..0 stay low;
- reset clears the outputs.

Other behaviour needs the bench's scripted sequences:
- little-endian lane placement in the pointer;
- dropping of misaligned pointer writes;
- the priority of an event over a clearing write in the same cycle;
- isolation between channels;
- preservation of the capability bits across clears.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_RSVD = 2'd3
    } acc_size_e;

    localparam int SLICE_BYTES = 8;
    localparam int PTR_W       = 32;

    // control byte fields
    localparam int CTL_RUN = 0;
    localparam int CTL_DIR = 3;
    // state byte fields
    localparam int ST_ACT  = 0;
    localparam int ST_ERR  = 1;
    localparam int ST_DONE = 2;
    localparam int ST_CAP0 = 5;
    localparam int ST_CAP1 = 6;

    typedef struct packed {
        logic       ptr_half;   // offset bit 2: pointer half of slice
        logic [1:0] lane;       // byte lane inside the 4-byte half
        logic       is_byte;    // single-byte access
        logic       aligned;    // naturally aligned, legal size
    } dec_t;

    typedef struct packed {
        logic              run;
        logic              dir;
        logic              err;
        logic              done;
        logic [1:0]        cap;
        logic [PTR_W-1:2]  ptr_hi;
    } chan_regs_t;

    function automatic logic [31:0] ones_of(acc_size_e s);
        case (s)
            SZ_BYTE: return 32'h0000_00FF;
            SZ_HALF: return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [3:0] lane_en(acc_size_e s, logic [1:0] lane);
        case (s)
            SZ_BYTE: return 4'b0001 << lane;
            SZ_HALF: return 4'b0011 << lane;
            default: return 4'b1111;
        endcase
    endfunction

    function automatic logic is_aligned(acc_size_e s, logic [1:0] lane);
        case (s)
            SZ_BYTE: return 1'b1;
            SZ_HALF: return ~lane[0];
            SZ_WORD: return lane == 2'd0;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] ctl_byte(chan_regs_t r);
        logic [7:0] b;
        b          = 8'h00;
        b[CTL_RUN] = r.run;
        b[CTL_DIR] = r.dir;
        return b;
    endfunction

    function automatic logic [7:0] st_byte(chan_regs_t r);
        logic [7:0] b;
        b          = 8'h00;
        b[ST_ACT]  = r.run;
        b[ST_ERR]  = r.err;
        b[ST_DONE] = r.done;
        b[ST_CAP0] = r.cap[0];
        b[ST_CAP1] = r.cap[1];
        return b;
    endfunction

endpackage

// File: rtl/bmdma_decode.sv
module bmdma_decode
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int AW    = CW + 3
) (
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [AW-1:0]     acc_addr,
    input  acc_size_e         size,
    output logic [CW-1:0]     chan,
    output dec_t              dec,
    output logic [NUM_CH-1:0] ctl_we,
    output logic [NUM_CH-1:0] st_we,
    output logic [NUM_CH*4-1:0] ptr_be
);

    logic wr;
    assign wr   = acc_valid & acc_write;
    assign chan = acc_addr[AW-1:3];

    always_comb begin
        dec.ptr_half = acc_addr[2];
        dec.lane     = acc_addr[1:0];
        dec.is_byte  = (size == SZ_BYTE);
        dec.aligned  = is_aligned(size, acc_addr[1:0]);
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
        logic hit;
        assign hit = wr && (chan == CW'(i));
        assign ctl_we[i] = hit && !dec.ptr_half && dec.is_byte && (dec.lane == 2'd0);
        assign st_we[i]  = hit && !dec.ptr_half && dec.is_byte && (dec.lane == 2'd2);
        assign ptr_be[i*4 +: 4] = (hit && dec.ptr_half && dec.aligned)
                                  ? lane_en(size, dec.lane) : 4'b0000;
    end

endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
    import bmdma_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctl_we,
    input  logic        st_we,
    input  logic [3:0]  ptr_be,
    input  logic [31:0] wbyte,     // right-justified data for control/state
    input  logic [31:0] wlane,     // data already shifted to its byte lanes
    input  logic        evt_done,
    input  logic        evt_err,
    output chan_regs_t  regs
);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
        end else begin
            if (ctl_we) begin
                regs.run <= wbyte[CTL_RUN];
                regs.dir <= wbyte[CTL_DIR];
            end
            // event set takes priority over a write-one clear
            if (evt_err)
                regs.err <= 1'b1;
            else if (st_we && wbyte[ST_ERR])
                regs.err <= 1'b0;
            if (evt_done)
                regs.done <= 1'b1;
            else if (st_we && wbyte[ST_DONE])
                regs.done <= 1'b0;
            if (st_we)
                regs.cap <= {wbyte[ST_CAP1], wbyte[ST_CAP0]};
            if (ptr_be[0]) regs.ptr_hi[7:2]   <= wlane[7:2];
            if (ptr_be[1]) regs.ptr_hi[15:8]  <= wlane[15:8];
            if (ptr_be[2]) regs.ptr_hi[23:16] <= wlane[23:16];
            if (ptr_be[3]) regs.ptr_hi[31:24] <= wlane[31:24];
        end
    end

endmodule

// File: rtl/bmdma_regwin.sv
module bmdma_regwin
    import bmdma_pkg::*;
#(
    parameter int NUM_CH = 2,
    localparam int CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int AW    = CW + 3
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  acc_valid,
    input  logic                  acc_write,
    input  logic [AW-1:0]         acc_addr,
    input  logic [1:0]            acc_size,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    input  logic [NUM_CH-1:0]     evt_done,
    input  logic [NUM_CH-1:0]     evt_err,
    output logic [NUM_CH-1:0]     run_o,
    output logic [NUM_CH-1:0]     dir_o,
    output logic [NUM_CH-1:0]     done_o,
    output logic [NUM_CH*32-1:0]  ptr_o
);

    acc_size_e             size;
    logic [CW-1:0]         chan;
    dec_t                  dec;
    logic [NUM_CH-1:0]     ctl_we;
    logic [NUM_CH-1:0]     st_we;
    logic [NUM_CH*4-1:0]   ptr_be;
    logic [31:0]           wlane;
    chan_regs_t            ch_regs [NUM_CH];

    assign size  = acc_size_e'(acc_size);
    assign wlane = wdata << {dec.lane, 3'b000};

    bmdma_decode #(.NUM_CH(NUM_CH)) u_dec (
        .acc_valid (acc_valid),
        .acc_write (acc_write),
        .acc_addr  (acc_addr),
        .size      (size),
        .chan      (chan),
        .dec       (dec),
        .ctl_we    (ctl_we),
        .st_we     (st_we),
        .ptr_be    (ptr_be)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        bmdma_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .ctl_we   (ctl_we[i]),
            .st_we    (st_we[i]),
            .ptr_be   (ptr_be[i*4 +: 4]),
            .wbyte    (wdata),
            .wlane    (wlane),
            .evt_done (evt_done[i]),
            .evt_err  (evt_err[i]),
            .regs     (ch_regs[i])
        );
        assign run_o[i]  = ch_regs[i].run;
        assign dir_o[i]  = ch_regs[i].dir;
        assign done_o[i] = ch_regs[i].done;
        assign ptr_o[i*32 +: 32] = {ch_regs[i].ptr_hi, 2'b00};
    end

    // read path: combinational, no side effects
    always_comb begin
        chan_regs_t  sel;
        logic [31:0] ones;
        logic [31:0] ptr_full;
        sel      = ch_regs[chan];
        ones     = ones_of(size);
        ptr_full = {sel.ptr_hi, 2'b00};
        if (!dec.ptr_half) begin
            if (!dec.is_byte) begin
                rdata = ones;
            end else begin
                case (dec.lane)
                    2'd0:    rdata = {24'h0, ctl_byte(sel)};
                    2'd2:    rdata = {24'h0, st_byte(sel)};
                    default: rdata = 32'h0000_00FF;
                endcase
            end
        end else if (!dec.aligned) begin
            rdata = ones;
        end else begin
            rdata = (ptr_full >> {dec.lane, 3'b000}) & ones;
        end
    end

endmodule

// File: rtl/bmdma_regwin_chk.sv
module bmdma_regwin_chk #(
    parameter int NUM_CH = 2,
    localparam int CW    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int AW    = CW + 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  acc_valid,
    input logic                  acc_write,
    input logic [AW-1:0]         acc_addr,
    input logic [1:0]            acc_size,
    input logic [31:0]           rdata,
    input logic [NUM_CH-1:0]     evt_done,
    input logic [NUM_CH-1:0]     run_o,
    input logic [NUM_CH-1:0]     dir_o,
    input logic [NUM_CH-1:0]     done_o,
    input logic [NUM_CH*32-1:0]  ptr_o
);

    logic [CW-1:0] ch;
    logic          rd, wr, lo_half;
    assign ch      = acc_addr[AW-1:3];
    assign rd      = acc_valid && !acc_write;
    assign wr      = acc_valid && acc_write;
    assign lo_half = !acc_addr[2];

    // R2
    ctl_rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && lo_half && acc_size == 2'd0 && acc_addr[1:0] == 2'd0)
        |-> (rdata & 32'hFFFF_FFF6) == 32'h0);

    // R3
    st_active_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && lo_half && acc_size == 2'd0 && acc_addr[1:0] == 2'd2)
        |-> rdata[0] == run_o[ch]);

    // R5
    odd_ff_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && lo_half && acc_size == 2'd0 && acc_addr[0])
        |-> rdata == 32'h0000_00FF);

    // R6
    wide_rd_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (rd && lo_half && acc_size != 2'd0)
        |-> rdata == ((acc_size == 2'd1) ? 32'h0000_FFFF : 32'hFFFF_FFFF));

    // R6
    wide_wr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (wr && lo_half && acc_size != 2'd0)
        |=> ($stable(run_o) && $stable(dir_o)));

    // R4
    done_set_chk: assert property (@(posedge clk) disable iff (rst)
        (evt_done != '0) |=> ((done_o & $past(evt_done)) == $past(evt_done)));

    // R7
    ptr_lowbits_chk: assert property (@(posedge clk) disable iff (rst)
        acc_valid || !acc_valid |-> (ptr_o[1:0] == 2'b00 && ptr_o[NUM_CH*32-31 -: 2] == 2'b00));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (run_o == '0 && dir_o == '0 && done_o == '0 && ptr_o == '0));

endmodule

bind bmdma_regwin bmdma_regwin_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_addr  (acc_addr),
    .acc_size  (acc_size),
    .rdata     (rdata),
    .evt_done  (evt_done),
    .run_o     (run_o),
    .dir_o     (dir_o),
    .done_o    (done_o),
    .ptr_o     (ptr_o)
);

// File: tb/sim_bmdma_regwin.sv
`timescale 1ns/1ps
module sim_bmdma_regwin;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [3:0]  acc_addr  = '0;
    logic [1:0]  acc_size  = '0;
    logic [31:0] wdata     = '0;
    logic [31:0] rdata;
    logic [1:0]  evt_done  = '0;
    logic [1:0]  evt_err   = '0;
    logic [1:0]  run_o, dir_o, done_o;
    logic [63:0] ptr_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] rd_cap;

    always #2.5 clk = ~clk;

    bmdma_regwin u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_addr(acc_addr), .acc_size(acc_size), .wdata(wdata), .rdata(rdata),
        .evt_done(evt_done), .evt_err(evt_err), .run_o(run_o), .dir_o(dir_o),
        .done_o(done_o), .ptr_o(ptr_o)
    );

    // entry: {write, addr[3:0], size[1:0], wdata[31:0], expected[31:0]}
    localparam int NV = 39;
    localparam logic [70:0] VEC [NV] = '{
        {1'b1, 4'h0, 2'd0, 32'h0000_00FF, 32'h0},          // R2 write control ch0
        {1'b0, 4'h0, 2'd0, 32'h0,         32'h0000_0009},  // R2 only run/dir kept
        {1'b0, 4'h2, 2'd0, 32'h0,         32'h0000_0001},  // R3 active mirrors run
        {1'b1, 4'h2, 2'd0, 32'h0000_0060, 32'h0},          // R3 capability bits
        {1'b0, 4'h2, 2'd0, 32'h0,         32'h0000_0061},  // R3
        {1'b0, 4'h1, 2'd0, 32'h0,         32'h0000_00FF},  // R5
        {1'b0, 4'h3, 2'd0, 32'h0,         32'h0000_00FF},  // R5
        {1'b0, 4'h0, 2'd1, 32'h0,         32'h0000_FFFF},  // R6 half read
        {1'b0, 4'h2, 2'd2, 32'h0,         32'hFFFF_FFFF},  // R6 word read
        {1'b0, 4'h0, 2'd3, 32'h0,         32'hFFFF_FFFF},  // R6 reserved size
        {1'b1, 4'h0, 2'd1, 32'h0,         32'h0},          // R6 wide write dropped
        {1'b1, 4'h2, 2'd2, 32'h0,         32'h0},          // R6 wide write dropped
        {1'b0, 4'h0, 2'd0, 32'h0,         32'h0000_0009},  // R6
        {1'b0, 4'h2, 2'd0, 32'h0,         32'h0000_0061},  // R6
        {1'b1, 4'h1, 2'd0, 32'h0,         32'h0},          // R5 ignored write
        {1'b1, 4'h3, 2'd0, 32'h0,         32'h0},          // R5 ignored write
        {1'b0, 4'h0, 2'd0, 32'h0,         32'h0000_0009},  // R5
        {1'b0, 4'h2, 2'd0, 32'h0,         32'h0000_0061},  // R5
        {1'b1, 4'h4, 2'd2, 32'h1234_5677, 32'h0},          // R7 word write
        {1'b0, 4'h4, 2'd2, 32'h0,         32'h1234_5674},  // R7 low bits forced
        {1'b0, 4'h5, 2'd0, 32'h0,         32'h0000_0056},  // R7 byte lane 1
        {1'b0, 4'h6, 2'd1, 32'h0,         32'h0000_1234},  // R7 upper half
        {1'b0, 4'h4, 2'd0, 32'h0,         32'h0000_0074},  // R7 byte lane 0
        {1'b1, 4'h7, 2'd0, 32'h0000_00AB, 32'h0},          // R7 byte write lane 3
        {1'b0, 4'h4, 2'd2, 32'h0,         32'hAB34_5674},  // R7
        {1'b1, 4'h4, 2'd1, 32'h0000_FFFF, 32'h0},          // R7 half write
        {1'b0, 4'h4, 2'd2, 32'h0,         32'hAB34_FFFC},  // R7
        {1'b0, 4'h5, 2'd1, 32'h0,         32'h0000_FFFF},  // R8 misaligned read
        {1'b1, 4'h6, 2'd2, 32'h0,         32'h0},          // R8 misaligned write
        {1'b0, 4'h4, 2'd2, 32'h0,         32'hAB34_FFFC},  // R8 dropped
        {1'b1, 4'h8, 2'd0, 32'h0000_0008, 32'h0},          // R1 ch1 control
        {1'b0, 4'h8, 2'd0, 32'h0,         32'h0000_0008},  // R1
        {1'b0, 4'hA, 2'd0, 32'h0,         32'h0000_0000},  // R1 ch1 state
        {1'b0, 4'h0, 2'd0, 32'h0,         32'h0000_0009},  // R1 ch0 untouched
        {1'b1, 4'hC, 2'd2, 32'hCAFE_BABF, 32'h0},          // R1 ch1 pointer
        {1'b0, 4'hC, 2'd2, 32'h0,         32'hCAFE_BABC},  // R1
        {1'b0, 4'h4, 2'd2, 32'h0,         32'hAB34_FFFC},  // R1 ch0 pointer kept
        {1'b1, 4'h0, 2'd0, 32'h0,         32'h0},          // R2 stop ch0
        {1'b0, 4'h2, 2'd0, 32'h0,         32'h0000_0060}   // R3 active follows run
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [3:0] a, input logic [1:0] sz,
                          input logic [31:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = wr; acc_addr = a; acc_size = sz; wdata = d;
        #1 rd_cap = rdata;
        @(posedge clk);
        #1 acc_valid = 1'b0; acc_write = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #1000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R9 reset state
        check("R9 outputs", {58'h0, run_o, dir_o, done_o}, 64'h0);
        check("R9 ptr", ptr_o, 64'h0);
        access(1'b0, 4'h2, 2'd0, 0); check("R9 state ch0", rd_cap, 32'h0);
        access(1'b0, 4'hC, 2'd2, 0); check("R9 ptr ch1", rd_cap, 32'h0);

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][70], VEC[i][69:66], VEC[i][65:64], VEC[i][63:32]);
            if (!VEC[i][70])
                check($sformatf("vector %0d", i), rd_cap, VEC[i][31:0]);
        end
        check("R2 run/dir outputs", {60'h0, run_o, dir_o}, {60'h0, 2'b00, 2'b10});
        check("R7 ptr outputs", ptr_o, 64'hCAFE_BABC_AB34_FFFC);

        // R4 events set sticky bits
        @(negedge clk) begin evt_done = 2'b01; evt_err = 2'b01; end
        @(posedge clk); #1 begin evt_done = 2'b00; evt_err = 2'b00; end
        check("R4 done_o", {62'h0, done_o}, 64'h1);
        access(1'b0, 4'h2, 2'd0, 0); check("R4 state set", rd_cap, 32'h66);
        access(1'b1, 4'h2, 2'd0, 32'h64);
        access(1'b0, 4'h2, 2'd0, 0); check("R4 clear done", rd_cap, 32'h62);
        check("R4 done_o cleared", {62'h0, done_o}, 64'h0);
        access(1'b1, 4'h2, 2'd0, 32'h62);
        access(1'b0, 4'h2, 2'd0, 0); check("R4 clear fault", rd_cap, 32'h60);
        // R4 event wins over simultaneous clear
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_addr = 4'h2; acc_size = 2'd0;
        wdata = 32'h64; evt_done = 2'b01;
        @(posedge clk); #1 begin acc_valid = 1'b0; acc_write = 1'b0; evt_done = 2'b00; end
        access(1'b0, 4'h2, 2'd0, 0); check("R4 set priority", rd_cap, 32'h64);
        access(1'b0, 4'hA, 2'd0, 0); check("R1 ch1 state isolated", rd_cap, 32'h0);

        // R9 reset mid-run
        @(negedge clk) rst = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check("R9 outputs after reset", {58'h0, run_o, dir_o, done_o}, 64'h0);
        check("R9 ptr after reset", ptr_o, 64'h0);
        access(1'b0, 4'h2, 2'd0, 0); check("R9 state after reset", rd_cap, 32'h0);

        finish_run();
    end

endmodule